// File: doc/BRIEF.md
# Polled Memory-Mapped Device Port

This block sits on the processor's load/store bus and takes the top 64 KiB of a 32-bit address space away from memory. An access in that window reaches a small set of device registers. An access outside it raises a memory-select line so the memory system answers it. No special I/O operations exist: ordinary loads read the device and ordinary stores write it.

The peripheral side has two byte channels, each with a status word and a data word.

- **Input channel.** The device pushes a byte with a strobe. This sets the channel's ready flag. Software polls the status word and then loads the data word, and that load drops the flag again.
- **Output channel.** The device pulses a "free" line to say it can take a byte. This sets the output ready flag. A store to the output data word hands the byte to the device and drops the flag.

All flags and data registers clear on a synchronous active-low reset. Reads are combinational in the access cycle. Flag changes take effect at the clock edge that ends the access.

Top module: `mmio_poll_port`

## Requirements
- R1: An access (load or store) whose address bits [31:16] are all ones drives mem_sel low and reaches the device registers. An access at any other address drives mem_sel high. With no access, mem_sel is low.
- R2: After reset, both ready flags are 0, both data registers hold 0, out_load is 0, and every device register reads 0.
- R3: A cycle with in_strobe high captures in_byte into the input data register and sets the input ready flag at that clock edge. A load from 0xFFFF0000 returns the input ready flag in bit 0 and zeros elsewhere.
- R4: A load from 0xFFFF0004 returns the input byte zero-extended in bits [7:0]. It clears the input ready flag at the end of that cycle. The data register keeps its value.
- R5: If in_strobe is high in the same cycle as a load from 0xFFFF0004, the load returns the old byte, the new byte is captured, and the input ready flag stays 1.
- R6: A cycle with out_free high sets the output ready flag. A load from 0xFFFF0008 returns the output ready flag in bit 0 and zeros elsewhere.
- R7: A store to 0xFFFF000C does three things. It puts bus_wdata[7:0] on out_byte from the next cycle on. It pulses out_load high for exactly that next cycle. It clears the output ready flag. A load from 0xFFFF000C returns the last stored byte and does not change any flag.
- R8: Stores to 0xFFFF0000 or 0xFFFF0008 leave both ready flags unchanged. Loads from the status words do not clear them.
- R9: Address bits [1:0] are ignored. For example, 0xFFFF0007 acts as 0xFFFF0004, and 0xFFFF0003 acts as 0xFFFF0000.
- R10: Three kinds of access change no flag or data register and cause no out_load:
  - any access outside the window, where a load also returns 0 on bus_rdata;
  - any access to an unmapped window offset (offset 0x10 or above), where a load returns 0;
  - a store to 0xFFFF0004.
- R11: If out_free is high in the same cycle as a store to 0xFFFF000C, the byte is still delivered and the output ready flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 32 | Byte address of the load or store |
| bus_rd | input | 1 | Load request this cycle |
| bus_wr | input | 1 | Store request this cycle |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load data from device registers, 0 otherwise |
| mem_sel | output | 1 | Access belongs to memory, not to the device |
| in_strobe | input | 1 | Device presents a new input byte |
| in_byte | input | 8 | Input byte from the device |
| out_free | input | 1 | Device can accept an output byte |
| out_byte | output | 8 | Last byte stored for the device |
| out_load | output | 1 | One-cycle pulse: out_byte is new |

## Verification
The assertions take for granted two things about the bus. First, bus_rd and bus_wr are never both high in the same cycle. Second, the device strobes are low while reset is held, because the first checked edge compares against the reset-cycle values. The stimulus drives every input on the falling clock edge and issues one access per cycle, never a load and a store together. It keeps both strobes idle during reset. It creates the two collision cases on purpose: a strobe in the same cycle as the data load, and out_free in the same cycle as the data store.

// File: rtl/io_pkg.sv
// io_pkg: shared register indices for the polled device port.
// Assumes word-aligned register slots at the bottom of the I/O window.
package io_pkg;
    localparam int NREG        = 4;
    localparam int IDX_IN_STAT = 0;  // offset 0x0
    localparam int IDX_IN_DATA = 1;  // offset 0x4
    localparam int IDX_OUT_STAT = 2; // offset 0x8
    localparam int IDX_OUT_DATA = 3; // offset 0xC
endpackage

// File: rtl/io_win_decode.sv
// io_win_decode: splits bus accesses between memory and device registers.
// The window is every address whose bits above WIN_LSB are all ones.
// Byte-lane bits [1:0] are ignored. Assumes rd and wr are never both high.
module io_win_decode #(
    parameter int ADDR_W  = 32,
    parameter int WIN_LSB = 16,
    parameter int NREG    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output logic              mem_sel,
    output logic [NREG-1:0]   rd_hit,
    output logic [NREG-1:0]   wr_hit
);
    localparam int OFS_W = WIN_LSB - 2;

    logic             in_win;
    logic [OFS_W-1:0] word_ofs;
    logic [NREG-1:0]  slot_hit;
    logic [1:0]       unused_lane;

    assign in_win      = &addr[ADDR_W-1:WIN_LSB];
    assign word_ofs    = addr[WIN_LSB-1:2];
    assign unused_lane = addr[1:0];
    assign mem_sel     = (rd | wr) & ~in_win;

    // one comparator per register slot
    for (genvar i = 0; i < NREG; i++) begin : g_slot
        assign slot_hit[i] = in_win && (word_ofs == OFS_W'(i));
        assign rd_hit[i]   = slot_hit[i] & rd;
        assign wr_hit[i]   = slot_hit[i] & wr;
    end

    // R1
    mem_dev_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_sel && ((|rd_hit) || (|wr_hit))));
endmodule

// File: rtl/io_in_chan.sv
// io_in_chan: input channel holding the device byte and its ready flag.
// A device strobe captures a byte and sets ready. A processor take clears
// ready. If both happen in the same cycle, the strobe wins.
module io_in_chan #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [BYTE_W-1:0] dev_byte,
    input  logic              take,
    output logic              ready,
    output logic [BYTE_W-1:0] data
);
    // ready flag: the device sets it, the data load clears it
    always_ff @(posedge clk) begin
        if (!rst_n)      ready <= 1'b0;
        else if (strobe) ready <= 1'b1;
        else if (take)   ready <= 1'b0;
    end

    // data holding register: loaded only by the device strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      data <= '0;
        else if (strobe) data <= dev_byte;
    end

    // R5
    in_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (ready && data == $past(dev_byte)));
    // R4
    in_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !strobe) |=> !ready);
    // R8
    in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !strobe) |=> ($stable(ready) && $stable(data)));
endmodule

// File: rtl/io_out_chan.sv
// io_out_chan: output channel holding the byte for the device and its
// ready flag. The device's free pulse sets ready. A processor store clears
// ready, latches the byte and pulses load for one cycle. If free and the
// store happen in the same cycle, free wins for the flag.
module io_out_chan #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              free,
    input  logic              put,
    input  logic [BYTE_W-1:0] put_byte,
    output logic              ready,
    output logic [BYTE_W-1:0] data,
    output logic              load
);
    // ready flag: the device sets it, the data store clears it
    always_ff @(posedge clk) begin
        if (!rst_n)    ready <= 1'b0;
        else if (free) ready <= 1'b1;
        else if (put)  ready <= 1'b0;
    end

    // output byte register and its one-cycle delivery pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
            load <= 1'b0;
        end else begin
            load <= put;
            if (put) data <= put_byte;
        end
    end

    // R7
    out_deliver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        put |=> (load && data == $past(put_byte)));
    // R7
    out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !put |=> (!load && $stable(data)));
    // R11
    out_free_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free |=> ready);
    // R7
    out_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (put && !free) |=> !ready);
    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!put && !free) |=> $stable(ready));
endmodule

// File: rtl/mmio_poll_port.sv
// mmio_poll_port: polled device port mapped into the top of the address space.
// Loads and stores in the window reach status and data words of an input
// and an output channel. Other accesses raise mem_sel. Load data is
// combinational. Assumes one access per cycle and a synchronous active-low reset.
module mmio_poll_port #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int BYTE_W  = 8,
    parameter int WIN_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              mem_sel,
    input  logic              in_strobe,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              out_free,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_load
);
    import io_pkg::*;

    localparam int PAD_W = DATA_W - BYTE_W;

    logic [NREG-1:0]   rd_hit;
    logic [NREG-1:0]   wr_hit;
    logic              in_ready;
    logic [BYTE_W-1:0] in_data;
    logic              out_ready;
    logic [DATA_W-1:0] reg_val [NREG];
    logic [PAD_W-1:0]  unused_wdata_hi;
    logic [3:0]        unused_wr_hit;

    // Only the low byte of store data and the output data slot's write
    // strobe are consumed.
    assign unused_wdata_hi = bus_wdata[DATA_W-1:BYTE_W];
    assign unused_wr_hit   = 4'(wr_hit & ~(NREG'(1) << IDX_OUT_DATA));

    io_win_decode #(
        .ADDR_W (ADDR_W),
        .WIN_LSB(WIN_LSB),
        .NREG   (NREG)
    ) i_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (bus_addr),
        .rd     (bus_rd),
        .wr     (bus_wr),
        .mem_sel(mem_sel),
        .rd_hit (rd_hit),
        .wr_hit (wr_hit)
    );

    io_in_chan #(.BYTE_W(BYTE_W)) i_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (in_strobe),
        .dev_byte(in_byte),
        .take    (rd_hit[IDX_IN_DATA]),
        .ready   (in_ready),
        .data    (in_data)
    );

    io_out_chan #(.BYTE_W(BYTE_W)) i_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .free    (out_free),
        .put     (wr_hit[IDX_OUT_DATA]),
        .put_byte(bus_wdata[BYTE_W-1:0]),
        .ready   (out_ready),
        .data    (out_byte),
        .load    (out_load)
    );

    assign reg_val[IDX_IN_STAT]  = DATA_W'(in_ready);
    assign reg_val[IDX_IN_DATA]  = {{PAD_W{1'b0}}, in_data};
    assign reg_val[IDX_OUT_STAT] = DATA_W'(out_ready);
    assign reg_val[IDX_OUT_DATA] = {{PAD_W{1'b0}}, out_byte};

    // load data: OR together the selected slots, 0 when none is selected
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_hit[i]) bus_rdata = bus_rdata | reg_val[i];
        end
    end

    // R10
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && mem_sel) |-> (bus_rdata == '0));
    // R3
    status_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit[IDX_IN_STAT] || rd_hit[IDX_OUT_STAT]) |-> (bus_rdata[DATA_W-1:1] == '0));
endmodule

// File: tb/test_mmio_poll_port.sv
`timescale 1ns/1ps
module test_mmio_poll_port;
    localparam int CLK_PERIOD = 10;
    localparam int SAMPLE_DLY = 3;
    localparam logic [31:0] A_IN_STAT  = 32'hFFFF_0000;
    localparam logic [31:0] A_IN_DATA  = 32'hFFFF_0004;
    localparam logic [31:0] A_OUT_STAT = 32'hFFFF_0008;
    localparam logic [31:0] A_OUT_DATA = 32'hFFFF_000C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mem_sel;
    logic        in_strobe = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        out_free = 1'b0;
    logic [7:0]  out_byte;
    logic        out_load;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] q_data[$];
    logic        q_msel[$];
    string       q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mmio_poll_port i_mmio_poll_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mem_sel(mem_sel), .in_strobe(in_strobe), .in_byte(in_byte),
        .out_free(out_free), .out_byte(out_byte), .out_load(out_load)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver: applies one cycle of inputs and queues the expected access result
    task automatic drive(input logic rd, input logic wr, input logic [31:0] a,
                         input logic [31:0] wd, input logic istr, input logic [7:0] ib,
                         input logic fr, input logic [31:0] exp_d, input logic exp_m,
                         input string tag);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        in_strobe = istr; in_byte = ib; out_free = fr;
        if (rd || wr) begin
            q_data.push_back(exp_d);
            q_msel.push_back(exp_m);
            q_tag.push_back(tag);
        end
    endtask

    task automatic idle(input logic istr = 1'b0, input logic [7:0] ib = 8'h00,
                        input logic fr = 1'b0);
        drive(1'b0, 1'b0, 32'h0, 32'h0, istr, ib, fr, 32'h0, 1'b0, "");
    endtask

    task automatic rd(input logic [31:0] a, input logic [31:0] exp, input logic m, input string tag);
        drive(1'b1, 1'b0, a, 32'h0, 1'b0, 8'h00, 1'b0, exp, m, tag);
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic m, input string tag);
        drive(1'b0, 1'b1, a, d, 1'b0, 8'h00, 1'b0, 32'h0, m, tag);
    endtask

    // monitor: pops the scoreboard and compares each access result
    initial begin
        forever begin
            @(negedge clk);
            #SAMPLE_DLY;
            if (bus_rd || bus_wr) begin
                if (q_tag.size() == 0) begin
                    n_chk++; n_fail++;
                    $display("FAIL scoreboard: access with no expectation, actual %h expected none", bus_addr);
                end else begin
                    logic [31:0] ed;
                    logic        em;
                    string       t;
                    ed = q_data.pop_front();
                    em = q_msel.pop_front();
                    t  = q_tag.pop_front();
                    chk({31'b0, mem_sel}, {31'b0, em}, {t, " mem_sel"});
                    if (bus_rd) chk(bus_rdata, ed, {t, " rdata"});
                end
            end
        end
    end

    // watchdog
    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) idle();
        #SAMPLE_DLY;
        chk({31'b0, out_load}, 32'h0, "R2 out_load in reset");
        chk({24'b0, out_byte}, 32'h0, "R2 out_byte in reset");
        @(negedge clk); rst_n = 1'b1;
        // R2 reset state readback
        rd(A_IN_STAT,  32'h0, 1'b0, "R2 in status");
        rd(A_IN_DATA,  32'h0, 1'b0, "R2 in data");
        rd(A_OUT_STAT, 32'h0, 1'b0, "R2 out status");
        rd(A_OUT_DATA, 32'h0, 1'b0, "R2 out data");
        // R1 window decode
        rd(32'h0000_1000, 32'h0, 1'b1, "R1 low address");
        wr(32'h8000_0000, 32'hDEAD_BEEF, 1'b1, "R1 mid address");
        rd(32'hFFFE_FFFC, 32'h0, 1'b1, "R1 just below window");
        rd(32'hFFFF_FFFC, 32'h0, 1'b0, "R1 top of window");
        idle();
        #SAMPLE_DLY;
        chk({31'b0, mem_sel}, 32'h0, "R1 no access");
        // R3 capture and status
        idle(1'b1, 8'hA5);
        rd(A_IN_STAT, 32'h1, 1'b0, "R3 ready set");
        rd(A_IN_STAT, 32'h1, 1'b0, "R8 status load keeps ready");
        // R4 data load clears ready
        rd(A_IN_DATA, 32'hA5, 1'b0, "R4 data byte");
        rd(A_IN_STAT, 32'h0, 1'b0, "R4 ready cleared");
        rd(A_IN_DATA, 32'hA5, 1'b0, "R4 data held");
        // R9 lane bits ignored
        idle(1'b1, 8'h3C);
        rd(32'hFFFF_0007, 32'h3C, 1'b0, "R9 alias of data");
        rd(32'hFFFF_0003, 32'h0, 1'b0, "R9 alias of status");
        // R5 strobe collides with data load
        idle(1'b1, 8'h11);
        drive(1'b1, 1'b0, A_IN_DATA, 32'h0, 1'b1, 8'h22, 1'b0, 32'h11, 1'b0, "R5 old byte returned");
        rd(A_IN_STAT, 32'h1, 1'b0, "R5 ready stays set");
        rd(A_IN_DATA, 32'h22, 1'b0, "R5 new byte captured");
        rd(A_IN_STAT, 32'h0, 1'b0, "R5 cleared afterwards");
        // R8 status stores have no effect
        idle(1'b1, 8'h55);
        wr(A_IN_STAT, 32'h0, 1'b0, "R8 store in status");
        rd(A_IN_STAT, 32'h1, 1'b0, "R8 in ready unchanged");
        wr(A_OUT_STAT, 32'hFFFF_FFFF, 1'b0, "R8 store out status");
        rd(A_OUT_STAT, 32'h0, 1'b0, "R8 out ready unchanged");
        rd(A_IN_DATA, 32'h55, 1'b0, "R8 drain input");
        // R6 free sets output ready
        idle(1'b0, 8'h00, 1'b1);
        rd(A_OUT_STAT, 32'h1, 1'b0, "R6 out ready set");
        // R7 store delivers byte
        wr(A_OUT_DATA, 32'h1234_56C7, 1'b0, "R7 store byte");
        rd(A_OUT_STAT, 32'h0, 1'b0, "R7 out ready cleared");
        #SAMPLE_DLY;
        chk({31'b0, out_load}, 32'h1, "R7 out_load pulse");
        chk({24'b0, out_byte}, 32'hC7, "R7 out_byte");
        rd(A_OUT_DATA, 32'hC7, 1'b0, "R7 out data readback");
        #SAMPLE_DLY;
        chk({31'b0, out_load}, 32'h0, "R7 pulse one cycle");
        // R11 free collides with store
        drive(1'b0, 1'b1, A_OUT_DATA, 32'h0000_009A, 1'b0, 8'h00, 1'b1, 32'h0, 1'b0, "R11 store with free");
        rd(A_OUT_STAT, 32'h1, 1'b0, "R11 ready ends set");
        #SAMPLE_DLY;
        chk({24'b0, out_byte}, 32'h9A, "R11 byte delivered");
        chk({31'b0, out_load}, 32'h1, "R11 out_load pulse");
        // R10 accesses with no effect
        idle(1'b1, 8'h77);
        rd(32'h0000_0004, 32'h0, 1'b1, "R10 outside load");
        wr(32'h0000_000C, 32'h0000_0011, 1'b1, "R10 outside store");
        #SAMPLE_DLY;
        chk({31'b0, out_load}, 32'h0, "R10 outside store no pulse");
        wr(A_IN_DATA, 32'h0000_00EE, 1'b0, "R10 store to input data");
        rd(A_IN_STAT, 32'h1, 1'b0, "R10 in ready kept");
        rd(A_IN_DATA, 32'h77, 1'b0, "R10 in data kept");
        wr(32'hFFFF_0010, 32'h0000_0033, 1'b0, "R10 unmapped store");
        rd(32'hFFFF_0010, 32'h0, 1'b0, "R10 unmapped load");
        wr(32'hFFFF_100C, 32'h0000_0044, 1'b0, "R10 far offset store");
        #SAMPLE_DLY;
        chk({31'b0, out_load}, 32'h0, "R10 far store no pulse");
        chk({24'b0, out_byte}, 32'h9A, "R10 out_byte kept");
        rd(A_OUT_STAT, 32'h1, 1'b0, "R10 out ready kept");
        idle();
        idle();
        chk(32'(q_tag.size()), 32'h0, "scoreboard drained");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule